// File: doc/BRIEF.md
# Flit Stitching Egress Queue

This queue sits in front of a slow link between GPU clusters. Each incoming flit carries a destination, a traffic class, a count of valid bytes and a payload. The two traffic classes are page-walk and bulk. A bulk flit that leaves enough bytes unused is parked in a small pool for a bounded time. A later bulk flit to the same destination can then be packed into the spare bytes of the parked flit. Each packed child is preceded by a one-byte sub-header so that the far end can separate it out again.

Page-walk flits never enter the pool. They go to a separate queue that wins the link over bulk traffic. Bulk flits that arrive nearly full skip the pool and join the bulk queue in arrival order. Flits are never dropped:

- A parked flit that cannot host the newcomer is sent at once.
- When the pool is full, the oldest parked flit is forced out.

Both the input and the link output use a valid/ready handshake.

Top module: `flit_stitch_egress`

## Requirements
- R1: After reset, out_valid_o is 0 and in_ready_o is 1 while no input is presented.
- R2: A bulk flit of at most 14 valid bytes that meets no partner becomes visible at the output 32 cycles after the edge that accepts it, when the output side is free.
- R3: Payload byte i is in bits [8i+7:8i]. A stitched child starts at the parent's current used-byte offset with a sub-header byte: child length in bits 7:4 and packet ID in bits 3:0. The child's bytes follow. out_used_o is the total byte count, out_lead_len_o is the length of the first packet and out_kids_o is the number of children.
- R4: A child merges only if its length plus 1 is no more than 16 minus the parent's used bytes. Otherwise the parked flit is sent at once and the newcomer takes its place in the pool.
- R5: Only flits with equal destination are stitched, and the pool holds at most one flit per destination.
- R6: A bulk flit that arrives with 15 or 16 bytes, or that is left with fewer than 2 free bytes by a merge, is not kept in the pool. It is visible after the accepting edge.
- R7: A page-walk flit is never pooled or stitched. It is visible unchanged after the accepting edge when the output side is free.
- R8: While a page-walk flit is waiting, the output presents page-walk traffic ahead of any bulk flit.
- R9: When all 8 pool entries are taken and a partial bulk flit for a new destination arrives, the oldest parked flit is sent at once.
- R10: Bulk packets to one destination leave in arrival order and none is lost. A near-full flit arriving while the same destination has a parked flit is taken one cycle later, after the parked flit has been sent.
- R11: Once out_valid_o is 1, it stays 1 until out_ready_i accepts a flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input flit valid |
| in_ready_o | output | 1 | Input flit accepted when high with valid |
| in_dest_i | input | 4 | Destination ID |
| in_walk_i | input | 1 | 1 = page-walk class, 0 = bulk |
| in_len_i | input | 5 | Valid bytes, 1 to 16 |
| in_pkt_id_i | input | 4 | Packet ID placed in the sub-header when stitched as a child |
| in_data_i | input | 128 | Payload, byte i in bits [8i+7:8i] |
| out_valid_o | output | 1 | Link flit valid |
| out_ready_i | input | 1 | Link accepts flit |
| out_dest_o | output | 4 | Destination of the link flit |
| out_walk_o | output | 1 | Class of the link flit |
| out_used_o | output | 5 | Bytes used in the link flit |
| out_lead_len_o | output | 5 | Length of the first packet |
| out_kids_o | output | 3 | Number of stitched children |
| out_data_o | output | 128 | Link payload, unused bytes zero |

## Verification
A flit that passes straight through is due at the sample point right after its accepting edge. This covers page-walk flits, near-full flits and a merge that fills its parent. A forced eviction for a full pool and a no-fit flush are due at that same point. A lone partial flit is due exactly 32 edges after acceptance. The bench records the cycle counter at acceptance and at the first sight of each output flit, then compares the difference with 0 or 32. It samples half a cycle after edges and drives one time step after them. Random traffic is checked by parsing every output flit through its sub-headers against per-destination expected queues.

// File: rtl/fsq_pkg.sv
`timescale 1ns/1ps
package fsq_pkg;
  parameter int FLIT_BYTES = 16;
  parameter int DEST_W     = 4;
  parameter int ID_W       = 4;
  localparam int LEN_W  = $clog2(FLIT_BYTES + 1);
  localparam int KID_W  = $clog2(FLIT_BYTES / 2);
  localparam int DATA_W = 8 * FLIT_BYTES;
  localparam int HLEN_W = 8 - ID_W;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              walk;
    logic [LEN_W-1:0]  used;
    logic [LEN_W-1:0]  lead;
    logic [KID_W-1:0]  kids;
    logic [DATA_W-1:0] data;
  } flit_t;
endpackage

// File: rtl/fsq_fifo.sv
`timescale 1ns/1ps
module fsq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          push_ok, pop_ok;

  assign full_o  = cnt == (AW+1)'(DEPTH);
  assign empty_o = cnt == '0;
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign dout_o  = mem[rp];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= wp + 1'b1;
      if (pop_ok)  rp <= rp + 1'b1;
      cnt <= cnt + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wp] <= din_i;
  end
endmodule

// File: rtl/fsq_pool.sv
`timescale 1ns/1ps
module fsq_pool import fsq_pkg::*; #(
  parameter int DEPTH    = 8,
  parameter int WAIT_CYC = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic                     keep_age_i,
  input  logic [$clog2(DEPTH)-1:0] wr_idx_i,
  input  flit_t                    wr_flit_i,
  input  logic                     clr_i,
  input  logic [$clog2(DEPTH)-1:0] clr_idx_i,
  input  logic [DEST_W-1:0]        dest_i,
  output flit_t                    ent_o [DEPTH],
  output logic [DEPTH-1:0]         vld_o,
  output logic                     hit_o,
  output logic [$clog2(DEPTH)-1:0] hit_idx_o,
  output logic                     free_o,
  output logic [$clog2(DEPTH)-1:0] free_idx_o,
  output logic [$clog2(DEPTH)-1:0] old_idx_o,
  output logic                     old_exp_o
);
  localparam int IW    = $clog2(DEPTH);
  localparam int AGE_W = $clog2(WAIT_CYC);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WAIT_CYC - 1);

  logic [AGE_W-1:0] age [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [AGE_W-1:0] age_nx;
    assign age_nx = (age[i] == AGE_MAX) ? age[i] : age[i] + 1'b1;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_o[i] <= 1'b0;
        age[i]   <= '0;
        ent_o[i] <= '0;
      end else if (clr_i && clr_idx_i == IW'(i)) begin
        vld_o[i] <= 1'b0;
      end else if (wr_i && wr_idx_i == IW'(i)) begin
        vld_o[i] <= 1'b1;
        ent_o[i] <= wr_flit_i;
        age[i]   <= keep_age_i ? age_nx : '0;
      end else if (vld_o[i]) begin
        age[i] <= age_nx;
      end
    end
  end

  logic [AGE_W-1:0] best;
  logic             any;

  always_comb begin
    hit_o      = 1'b0;
    hit_idx_o  = '0;
    free_o     = 1'b0;
    free_idx_o = '0;
    old_idx_o  = '0;
    best       = '0;
    any        = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_o[i] && ent_o[i].dest == dest_i && !hit_o) begin
        hit_o     = 1'b1;
        hit_idx_o = IW'(i);
      end
      if (!vld_o[i] && !free_o) begin
        free_o     = 1'b1;
        free_idx_o = IW'(i);
      end
      // strict compare: lowest index wins a tie
      if (vld_o[i] && (!any || age[i] > best)) begin
        any       = 1'b1;
        best      = age[i];
        old_idx_o = IW'(i);
      end
    end
    old_exp_o = any && best == AGE_MAX;
  end
endmodule

// File: rtl/fsq_stitch.sv
`timescale 1ns/1ps
module fsq_stitch import fsq_pkg::*; (
  input  flit_t             par_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [DATA_W-1:0] data_i,
  output flit_t             out_o,
  output logic              fits_o,
  output logic              done_o
);
  logic [LEN_W:0]   need, room, total;
  logic [LEN_W+3:0] sh_hdr, sh_kid;
  logic [7:0]       hdr;

  always_comb begin
    need   = (LEN_W+1)'(len_i) + 1'b1;
    room   = (LEN_W+1)'(FLIT_BYTES) - (LEN_W+1)'(par_i.used);
    total  = (LEN_W+1)'(par_i.used) + need;
    fits_o = need <= room;
    done_o = total >= (LEN_W+1)'(FLIT_BYTES - 1);
    hdr    = {len_i[HLEN_W-1:0], id_i};
    sh_hdr = {1'b0, par_i.used, 3'b000};
    sh_kid = sh_hdr + (LEN_W+4)'(8);
    out_o      = par_i;
    out_o.used = total[LEN_W-1:0];
    out_o.kids = par_i.kids + 1'b1;
    out_o.data = par_i.data | (DATA_W'(hdr) << sh_hdr) | (data_i << sh_kid);
  end
endmodule

// File: rtl/flit_stitch_egress.sv
`timescale 1ns/1ps
module flit_stitch_egress import fsq_pkg::*; #(
  parameter int POOL_DEPTH = 8,
  parameter int WAIT_CYC   = 32,
  parameter int BULK_DEPTH = 8,
  parameter int WALK_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DEST_W-1:0] in_dest_i,
  input  logic              in_walk_i,
  input  logic [LEN_W-1:0]  in_len_i,
  input  logic [ID_W-1:0]   in_pkt_id_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DEST_W-1:0] out_dest_o,
  output logic              out_walk_o,
  output logic [LEN_W-1:0]  out_used_o,
  output logic [LEN_W-1:0]  out_lead_len_o,
  output logic [KID_W-1:0]  out_kids_o,
  output logic [DATA_W-1:0] out_data_o
);
  localparam int IW = $clog2(POOL_DEPTH);
  localparam int FW = $bits(flit_t);

  // input shaping
  logic [DATA_W-1:0] in_mdata;
  flit_t             in_flit;
  logic              in_roomy;

  always_comb begin
    for (int b = 0; b < FLIT_BYTES; b++)
      in_mdata[8*b +: 8] = (LEN_W'(b) < in_len_i) ? in_data_i[8*b +: 8] : 8'h00;
    in_flit      = '0;
    in_flit.dest = in_dest_i;
    in_flit.walk = in_walk_i;
    in_flit.used = in_len_i;
    in_flit.lead = in_len_i;
    in_flit.data = in_mdata;
  end
  assign in_roomy = in_len_i <= LEN_W'(FLIT_BYTES - 2);

  // pool
  logic                  p_wr, p_keep, p_clr;
  logic [IW-1:0]         p_wr_idx, p_clr_idx;
  flit_t                 p_wr_flit;
  flit_t                 p_ent [POOL_DEPTH];
  logic [POOL_DEPTH-1:0] p_vld;
  logic                  p_hit, p_free, p_old_exp;
  logic [IW-1:0]         p_hit_idx, p_free_idx, p_old_idx;

  fsq_pool #(.DEPTH(POOL_DEPTH), .WAIT_CYC(WAIT_CYC)) u_pool (
    .clk_i, .rst_ni,
    .wr_i(p_wr), .keep_age_i(p_keep), .wr_idx_i(p_wr_idx), .wr_flit_i(p_wr_flit),
    .clr_i(p_clr), .clr_idx_i(p_clr_idx), .dest_i(in_dest_i),
    .ent_o(p_ent), .vld_o(p_vld),
    .hit_o(p_hit), .hit_idx_o(p_hit_idx),
    .free_o(p_free), .free_idx_o(p_free_idx),
    .old_idx_o(p_old_idx), .old_exp_o(p_old_exp)
  );

  logic [POOL_DEPTH-1:0][LEN_W-1:0]  p_used_v;
  logic [POOL_DEPTH-1:0][DEST_W-1:0] p_dest_v;
  for (genvar i = 0; i < POOL_DEPTH; i++) begin : g_view
    assign p_used_v[i] = p_ent[i].used;
    assign p_dest_v[i] = p_ent[i].dest;
  end

  // merge candidate
  flit_t par, merged;
  logic  fits, filled;
  assign par = p_ent[p_hit_idx];

  fsq_stitch u_stitch (
    .par_i(par), .len_i(in_len_i), .id_i(in_pkt_id_i), .data_i(in_mdata),
    .out_o(merged), .fits_o(fits), .done_o(filled)
  );

  // queues
  logic  bq_push, bq_full, bq_empty, bq_pop;
  logic  wq_push, wq_full, wq_empty, wq_pop;
  flit_t bq_din, bq_head, wq_head;

  // single bulk push slot per cycle; expiry takes it first
  logic bulk_rdy;
  always_comb begin
    bq_push   = 1'b0;
    bq_din    = in_flit;
    p_wr      = 1'b0;
    p_keep    = 1'b0;
    p_wr_idx  = '0;
    p_wr_flit = in_flit;
    p_clr     = 1'b0;
    p_clr_idx = '0;
    bulk_rdy  = 1'b0;
    if (!bq_full) begin
      if (p_old_exp) begin
        bq_push   = 1'b1;
        bq_din    = p_ent[p_old_idx];
        p_clr     = 1'b1;
        p_clr_idx = p_old_idx;
      end else if (!in_walk_i) begin
        if (!in_roomy) begin
          if (p_hit) begin
            // flush older same-destination flit, take input next cycle
            bq_push   = in_valid_i;
            bq_din    = par;
            p_clr     = in_valid_i;
            p_clr_idx = p_hit_idx;
          end else begin
            bulk_rdy = 1'b1;
            bq_push  = in_valid_i;
          end
        end else if (p_hit && fits) begin
          bulk_rdy = 1'b1;
          if (filled) begin
            bq_push   = in_valid_i;
            bq_din    = merged;
            p_clr     = in_valid_i;
            p_clr_idx = p_hit_idx;
          end else begin
            p_wr      = in_valid_i;
            p_keep    = 1'b1;
            p_wr_idx  = p_hit_idx;
            p_wr_flit = merged;
          end
        end else if (p_hit) begin
          bulk_rdy = 1'b1;
          bq_push  = in_valid_i;
          bq_din   = par;
          p_wr     = in_valid_i;
          p_wr_idx = p_hit_idx;
        end else if (p_free) begin
          bulk_rdy = 1'b1;
          p_wr     = in_valid_i;
          p_wr_idx = p_free_idx;
        end else begin
          bulk_rdy = 1'b1;
          bq_push  = in_valid_i;
          bq_din   = p_ent[p_old_idx];
          p_wr     = in_valid_i;
          p_wr_idx = p_old_idx;
        end
      end
    end
  end

  assign in_ready_o = in_walk_i ? !wq_full : bulk_rdy;
  assign wq_push    = in_valid_i && in_walk_i && !wq_full;

  fsq_fifo #(.W(FW), .DEPTH(BULK_DEPTH)) u_bulk_q (
    .clk_i, .rst_ni, .push_i(bq_push), .din_i(bq_din), .pop_i(bq_pop),
    .dout_o(bq_head), .full_o(bq_full), .empty_o(bq_empty)
  );

  fsq_fifo #(.W(FW), .DEPTH(WALK_DEPTH)) u_walk_q (
    .clk_i, .rst_ni, .push_i(wq_push), .din_i(in_flit), .pop_i(wq_pop),
    .dout_o(wq_head), .full_o(wq_full), .empty_o(wq_empty)
  );

  // output: page-walk first
  flit_t out_f;
  assign out_f          = !wq_empty ? wq_head : bq_head;
  assign out_valid_o    = !wq_empty || !bq_empty;
  assign wq_pop         = out_ready_i && !wq_empty;
  assign bq_pop         = out_ready_i && wq_empty && !bq_empty;
  assign out_dest_o     = out_f.dest;
  assign out_walk_o     = out_f.walk;
  assign out_used_o     = out_f.used;
  assign out_lead_len_o = out_f.lead;
  assign out_kids_o     = out_f.kids;
  assign out_data_o     = out_f.data;
endmodule

// File: rtl/fsq_chk.sv
`timescale 1ns/1ps
module fsq_chk import fsq_pkg::*; #(
  parameter int POOL_DEPTH = 8
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             out_valid_o,
  input logic                             out_ready_i,
  input logic                             out_walk_o,
  input logic [LEN_W-1:0]                 out_used_o,
  input logic [LEN_W-1:0]                 out_lead_len_o,
  input logic [KID_W-1:0]                 out_kids_o,
  input logic                             wq_empty,
  input logic [POOL_DEPTH-1:0]            p_vld,
  input logic [POOL_DEPTH-1:0][LEN_W-1:0] p_used_v,
  input logic [POOL_DEPTH-1:0][DEST_W-1:0] p_dest_v
);
  logic room_bad, dup_dest;
  always_comb begin
    room_bad = 1'b0;
    dup_dest = 1'b0;
    for (int i = 0; i < POOL_DEPTH; i++) begin
      if (p_vld[i] && p_used_v[i] > LEN_W'(FLIT_BYTES - 2)) room_bad = 1'b1;
      for (int j = i + 1; j < POOL_DEPTH; j++)
        if (p_vld[i] && p_vld[j] && p_dest_v[i] == p_dest_v[j]) dup_dest = 1'b1;
    end
  end

  // R8
  walk_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wq_empty |-> out_valid_o && out_walk_o);

  // R11
  hold_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o);

  // R6
  pool_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !room_bad);

  // R5
  one_per_dest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dup_dest);

  // R3
  used_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_used_o >= out_lead_len_o && out_used_o <= LEN_W'(FLIT_BYTES)
                    && (out_kids_o != '0 || out_used_o == out_lead_len_o));

  // R7
  walk_plain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_walk_o |-> out_kids_o == '0 && out_used_o == out_lead_len_o);
endmodule

bind flit_stitch_egress fsq_chk #(.POOL_DEPTH(POOL_DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_walk_o(out_walk_o),
  .out_used_o(out_used_o), .out_lead_len_o(out_lead_len_o), .out_kids_o(out_kids_o),
  .wq_empty(wq_empty), .p_vld(p_vld), .p_used_v(p_used_v), .p_dest_v(p_dest_v)
);

// File: tb/sim_flit_stitch_egress.sv
`timescale 1ns/1ps
module sim_flit_stitch_egress;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid = 1'b0, in_walk = 1'b0, out_ready = 1'b1;
  logic [3:0]   in_dest = '0, in_id = '0;
  logic [4:0]   in_len = 5'd1;
  logic [127:0] in_data = '0;
  logic         in_ready, out_valid, out_walk;
  logic [3:0]   out_dest;
  logic [4:0]   out_used, out_lead;
  logic [2:0]   out_kids;
  logic [127:0] out_data;

  always #2.5 clk = ~clk;

  flit_stitch_egress u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_dest_i(in_dest), .in_walk_i(in_walk),
    .in_len_i(in_len), .in_pkt_id_i(in_id), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_dest_o(out_dest), .out_walk_o(out_walk),
    .out_used_o(out_used), .out_lead_len_o(out_lead), .out_kids_o(out_kids), .out_data_o(out_data)
  );

  typedef struct packed { int len; int id; logic [127:0] data; } pkt_t;
  pkt_t bq[16][$];
  pkt_t wq[$];
  bit   walk_log[$];

  int total = 0, bad = 0, cyc = 0, nout = 0;
  int last_cyc, last_used, last_kids, last_dest;
  bit last_walk, rnd_on = 1'b0;
  logic [127:0] last_data;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] mask(logic [127:0] d, int len);
    logic [127:0] r = '0;
    for (int b = 0; b < 16; b++) if (b < len) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) if (cyc > 100000) begin
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // monitor: a flit seen valid+ready at a falling edge leaves at the next rising edge
  always @(negedge clk) if (rst_ni && out_valid && out_ready) begin
    pkt_t e;
    int pos, l;
    logic [7:0] hdr;
    nout++; last_cyc = cyc; last_used = out_used; last_kids = out_kids;
    last_dest = out_dest; last_walk = out_walk; last_data = out_data;
    walk_log.push_back(out_walk);
    if (out_walk) begin
      if (wq.size() == 0) chk(0, "R7", "unexpected walk flit", 1, 0);
      else begin
        e = wq.pop_front();
        chk(out_used == e.len && out_kids == 0 && out_data == e.data, "R7",
            "walk flit content (used)", out_used, e.len);
      end
    end else begin
      pos = out_lead;
      if (bq[out_dest].size() == 0) chk(0, "R10", "unexpected bulk flit dest", out_dest, -1);
      else begin
        e = bq[out_dest].pop_front();
        chk(e.len == out_lead && mask(out_data, out_lead) == e.data, "R10",
            "lead packet order/content (len)", out_lead, e.len);
        for (int k = 0; k < out_kids; k++) begin
          hdr = out_data[8*pos +: 8];
          l = hdr[7:4];
          if (bq[out_dest].size() == 0) chk(0, "R10", "extra child", l, -1);
          else begin
            e = bq[out_dest].pop_front();
            chk(l == e.len && hdr[3:0] == e.id[3:0] &&
                mask(out_data >> (8*(pos+1)), l) == e.data, "R3",
                "child sub-header/content (len)", l, e.len);
          end
          pos += l + 1;
        end
        chk(pos == out_used, "R3", "used byte total", out_used, pos);
      end
    end
  end

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) settle();
  endtask

  task automatic send(int dest, bit walk, int len, int id, output int acc);
    logic [127:0] d = {$urandom, $urandom, $urandom, $urandom};
    pkt_t p;
    @(posedge clk); #1;
    in_valid = 1'b1; in_dest = 4'(dest); in_walk = walk; in_len = 5'(len);
    in_id = 4'(id); in_data = d;
    forever begin @(negedge clk); if (in_ready) break; end
    @(posedge clk); #1;
    acc = cyc;
    in_valid = 1'b0;
    p.len = len; p.id = id; p.data = mask(d, len);
    if (walk) wq.push_back(p); else bq[dest].push_back(p);
  endtask

  task automatic wait_out(int n0, int lim);
    int t0 = cyc;
    while (nout == n0 && cyc < t0 + lim) settle();
  endtask

  initial begin
    out_ready = 1'b1;
    #2.5;
    if ($urandom(32'd7) == 0) ;
    idle(3);
    rst_ni = 1'b1;
    settle();
    // R1
    chk(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1, "R1", "in_ready after reset", in_ready, 1);
  end

  initial begin
    int a, b, c, n0, nl;
    wait (rst_ni);
    idle(3);

    // R2: lone partial flit waits 32 cycles
    n0 = nout;
    send(1, 0, 5, 2, a);
    wait_out(n0, 60);
    chk(last_cyc == a + 32, "R2", "timeout release cycle offset", last_cyc - a, 32);
    chk(last_used == 5 && last_kids == 0, "R2", "released flit used", last_used, 5);

    // R3/R4/R6: two children fill the parent
    idle(5);
    n0 = nout;
    send(2, 0, 4, 1, a);
    send(2, 0, 3, 7, b);
    send(2, 0, 6, 9, c);
    settle();
    chk(nout == n0 + 1 && last_cyc == c, "R6", "filled parent sent at accept (cycle offset)", last_cyc - c, 0);
    chk(last_used == 15, "R3", "stitched used", last_used, 15);
    chk(last_kids == 2, "R3", "child count", last_kids, 2);
    chk(last_data[39:32] == 8'h37, "R3", "first sub-header byte 4", last_data[39:32], 8'h37);
    chk(last_data[71:64] == 8'h69, "R3", "second sub-header byte 8", last_data[71:64], 8'h69);

    // R4: no fit flushes parent at once
    n0 = nout;
    send(3, 0, 10, 1, a);
    send(3, 0, 8, 4, b);
    settle();
    chk(nout == n0 + 1 && last_cyc == b, "R4", "no-fit parent flush (cycle offset)", last_cyc - b, 0);
    chk(last_used == 10 && last_kids == 0, "R4", "flushed parent used", last_used, 10);
    wait_out(n0 + 1, 60);
    chk(last_cyc == b + 32 && last_used == 8, "R4", "newcomer pooled then released (offset)", last_cyc - b, 32);

    // R5: different destinations not merged
    idle(3);
    n0 = nout;
    send(4, 0, 3, 1, a);
    send(5, 0, 3, 2, b);
    wait_out(n0, 60);
    chk(last_dest == 4 && last_kids == 0, "R5", "first dest unmerged", last_dest, 4);
    wait_out(n0 + 1, 10);
    chk(last_dest == 5 && last_kids == 0, "R5", "second dest unmerged", last_dest, 5);

    // R6: full flit bypasses pool
    idle(3);
    n0 = nout;
    send(6, 0, 16, 0, a);
    settle();
    chk(last_cyc == a && last_used == 16, "R6", "full flit immediate (cycle offset)", last_cyc - a, 0);

    // R10: full flit behind pooled same-destination flit
    n0 = nout;
    send(7, 0, 4, 0, a);
    send(7, 0, 16, 0, b);
    settle();
    chk(nout == n0 + 2 && last_used == 16, "R10", "pooled flushed ahead of full flit", nout - n0, 2);

    // R7: walk flit immediate, not stitched into pooled same dest
    n0 = nout;
    send(9, 0, 3, 0, a);
    send(9, 1, 2, 5, b);
    settle();
    chk(last_cyc == b && last_walk == 1 && last_kids == 0, "R7", "walk flit immediate (cycle offset)", last_cyc - b, 0);

    // R8/R11: priority and held valid
    @(posedge clk); #1; out_ready = 1'b0;
    send(10, 0, 16, 0, a);
    send(10, 1, 2, 3, b);
    idle(3);
    chk(out_valid == 1, "R11", "valid held while stalled", out_valid, 1);
    chk(out_walk == 1, "R8", "walk flit presented first", out_walk, 1);
    nl = walk_log.size();
    @(posedge clk); #1; out_ready = 1'b1;
    idle(3);
    chk(walk_log.size() >= nl + 2 && walk_log[nl] == 1, "R8", "walk leaves before bulk", walk_log[nl], 1);

    // R9: pool overflow forces oldest out
    idle(45);
    for (int d = 0; d < 8; d++) send(d, 0, 2, 0, a);
    n0 = nout;
    send(8, 0, 2, 0, b);
    settle();
    chk(nout == n0 + 1 && last_cyc == b, "R9", "forced eviction at accept (cycle offset)", last_cyc - b, 0);
    chk(last_dest == 0, "R9", "oldest entry evicted", last_dest, 0);
    idle(45);

    // random phase
    rnd_on = 1'b1;
    for (int i = 0; i < 1500; i++) begin
      int r = $urandom % 10, len;
      if (r < 5) len = 1 + $urandom % 6;
      else if (r < 8) len = 7 + $urandom % 8;
      else len = 15 + $urandom % 2;
      send($urandom % 3, ($urandom % 10) == 0, len, $urandom % 16, a);
    end
    rnd_on = 1'b0;
    @(posedge clk); #1; out_ready = 1'b1;
    idle(100);
    begin
      int left = wq.size();
      for (int d = 0; d < 16; d++) left += bq[d].size();
      chk(left == 0, "R10", "packets left undelivered", left, 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial forever begin
    @(posedge clk); #1;
    if (rnd_on) out_ready = ($urandom % 10) < 7;
  end
endmodule